// File: doc/BRIEF.md
# I2C Master Byte Engine

This block drives an I2C bus as its master, one byte at a time. Software works it through two level control bits and a one-byte buffer. A rising edge on the start bit produces a START condition, or a repeated START if the bus is already held, and the buffer byte is then sent. A rising edge on the stop bit produces a STOP condition. Either edge acts only while no byte is being shifted.

After every byte, the engine parks SCL low and raises a done flag. It then waits for a buffer access. A write, or a read in receive mode, starts the next byte while the start bit is 1. Any access is ignored for a fixed settle window after the done flag rises.

The SCL and SDA lines are open-drain. Each is modelled as an output enable: 1 pulls the line low. Each bit is split into four quarter periods. A programmable divider sets the length of one quarter.

Top module: `i2cm_byte_engine`

## Requirements
- R1: From idle, a rising edge on `start_i` while `stop_i` is 0 gives a START condition. The buffer byte is then sent MSB first, as 8 SCL pulses followed by a 9th acknowledge pulse.
- R2: A rising edge on `stop_i` while not busy gives a STOP condition whatever `start_i` holds. Afterwards both line enables are 0 and `busy_o` is 0.
- R3: While the bus is held, `start_i` = 1 and an accepted buffer access starts the next byte. With `rx_i` = 0 the byte is sent, taking the written data on a write. With `rx_i` = 1 the byte is received into the buffer and read back on `buf_rdata_o`. An accepted write with `start_i` = 0 only loads the buffer.
- R4: Between bytes, `scl_oe_o` stays 1 and `busy_o` stays 0 until a STOP or a repeated START.
- R5: When receiving, the 9th bit driven on SDA is 1 (NACK) if `ack_sel_i` = 1 and 0 (ACK) if `ack_sel_i` = 0.
- R6: After a sent byte, `nack_o` equals the SDA level sampled on the 9th SCL high: 1 if the slave did not acknowledge, 0 if it did.
- R7: `done_o` goes to 1 when a byte completes and goes to 0 on `done_clr_i`. It is 0 after reset.
- R8: For SETTLE = CLK_HZ/100000 cycles after `done_o` rises, buffer accesses are ignored: nothing is loaded and no byte starts.
- R9: While the bus is held, a rising edge on `start_i` with `stop_i` = 0 gives a repeated START, followed by sending the buffer byte.
- R10: A start edge while a byte is in progress is ignored, as is a start edge while `stop_i` = 1.
- R11: SCL stays high for 2*(`qtr_div_i`+1) cycles per bit. During data bits, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qtr_div_i | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| start_i | input | 1 | Start control bit |
| stop_i | input | 1 | Stop control bit |
| rx_i | input | 1 | 1 = next resumed byte is received |
| ack_sel_i | input | 1 | 1 = return NACK after a received byte |
| buf_wr_i | input | 1 | Buffer write strobe |
| buf_rd_i | input | 1 | Buffer read strobe |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_rdata_o | output | 8 | Buffer contents |
| done_clr_i | input | 1 | Clears the done flag |
| done_o | output | 1 | Byte done flag |
| nack_o | output | 1 | 1 = last sent byte was not acknowledged |
| busy_o | output | 1 | START, byte, or STOP in progress |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The bench builds the engine with CLK_HZ = 1 MHz, which shrinks the settle window to 10 cycles, and with DIV_W = 4. It runs first with a quarter divider of 1 and then with 3. These values keep each byte within a few hundred cycles. They make it cheap both to hit the buffer inside the window and to wait it out, and they make the change in SCL high time directly measurable. A behavioural slave on the bus decodes START, STOP and bits, and it supplies either ACK or NACK, or data bytes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_TAIL,
    ST_HOLD,
    ST_STOP
  } i2cm_state_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cm_settle.sv
module i2cm_settle #(
  parameter int CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic open_o
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt_q;

  assign open_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (fire_i)       cnt_q <= W'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/i2cm_edge.sv
module i2cm_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int DIV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] qtr_div_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rx_i,
  input  logic             ack_sel_i,
  input  logic             buf_wr_i,
  input  logic             buf_rd_i,
  input  logic [7:0]       buf_wdata_i,
  output logic [7:0]       buf_rdata_o,
  input  logic             done_clr_i,
  output logic             done_o,
  output logic             nack_o,
  output logic             busy_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  // 10 us settle window in system clocks
  localparam int SETTLE_CYC = (CLK_HZ / 100_000 > 0) ? CLK_HZ / 100_000 : 1;

  i2cm_state_e state_q;
  logic [1:0]  ph_q;
  logic [3:0]  bit_q;
  logic [7:0]  sh_q;
  logic        rx_q, scl_low_q, sda_low_q, nack_q, done_q;

  logic [1:0] rise;
  logic       start_rise, stop_rise, tick, settle_open;
  logic       access, take, wr_take, resume, done_set, bit_drive;

  i2cm_edge #(.N(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({stop_i, start_i}),
    .rise_o(rise)
  );
  assign start_rise = rise[0];
  assign stop_rise  = rise[1];

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_HOLD);

  i2cm_qtick #(.W(DIV_W)) u_qtick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy_o),
    .div_i (qtr_div_i),
    .tick_o(tick)
  );

  assign done_set = (state_q == ST_TAIL) && tick;

  i2cm_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(done_set && !done_q),
    .open_o(settle_open)
  );

  assign access  = buf_wr_i | buf_rd_i;
  assign take    = access && settle_open && !busy_o;
  assign wr_take = take && buf_wr_i;
  assign resume  = (state_q == ST_HOLD) && take && start_i;
  // bit 8 is the acknowledge slot
  assign bit_drive = bit_q[3] ? (rx_q & ~ack_sel_i) : (~rx_q & ~sh_q[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ph_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      rx_q      <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      nack_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (done_set)        done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
      if (wr_take) sh_q <= buf_wdata_i;
      case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (stop_rise) begin
            state_q   <= ST_STOP;
            ph_q      <= '0;
            scl_low_q <= 1'b1;
          end else if (start_rise && !stop_i) begin
            state_q   <= ST_START;
            ph_q      <= '0;
            sda_low_q <= 1'b0;
            rx_q      <= 1'b0;
          end else if (resume) begin
            state_q <= ST_BIT;
            ph_q    <= '0;
            bit_q   <= '0;
            rx_q    <= rx_i;
          end
        end
        ST_START: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: scl_low_q <= 1'b0;
            2'd1: sda_low_q <= 1'b1;
            2'd2: scl_low_q <= 1'b1;
            default: begin
              state_q <= ST_BIT;
              bit_q   <= '0;
            end
          endcase
        end
        ST_BIT: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_low_q <= bit_drive;
            2'd1: scl_low_q <= 1'b0;
            2'd2: begin end
            default: begin
              scl_low_q <= 1'b1;
              bit_q     <= bit_q + 4'd1;
              if (bit_q[3]) begin
                state_q <= ST_TAIL;
                if (!rx_q) nack_q <= sda_i;
              end else begin
                sh_q <= {sh_q[6:0], sda_i};
              end
            end
          endcase
        end
        ST_TAIL: if (tick) begin
          sda_low_q <= 1'b0;
          state_q   <= ST_HOLD;
        end
        ST_STOP: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_low_q <= 1'b1;
            2'd1: scl_low_q <= 1'b0;
            2'd2: sda_low_q <= 1'b0;
            default: state_q <= ST_IDLE;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_rdata_o = sh_q;
  assign done_o      = done_q;
  assign nack_o      = nack_q;
  assign scl_oe_o    = scl_low_q;
  assign sda_oe_o    = sda_low_q;
endmodule

// File: rtl/i2cm_byte_engine_chk.sv
module i2cm_byte_engine_chk
  import i2cm_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input i2cm_state_e state_i,
  input logic        scl_oe_i,
  input logic        sda_oe_i,
  input logic        done_i,
  input logic        access_i,
  input logic        open_i
);
  a_r4_hold_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD) |-> scl_oe_i);

  a_r8_early_access_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD && access_i && !open_i) |=> (state_i != ST_BIT));

  a_r2_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && $past(state_i) == ST_STOP) |-> (!scl_oe_i && !sda_oe_i));

  a_r11_sda_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BIT && $past(state_i) == ST_BIT && !scl_oe_i && !$past(scl_oe_i))
      |-> $stable(sda_oe_i));

  a_r7_done_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (state_i == ST_HOLD && $past(state_i) == ST_TAIL));
endmodule

bind i2cm_byte_engine i2cm_byte_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (state_q),
  .scl_oe_i(scl_oe_o),
  .sda_oe_i(sda_oe_o),
  .done_i  (done_o),
  .access_i(access),
  .open_i  (settle_open)
);

// File: tb/i2cm_byte_engine_tb_top.sv
module i2cm_byte_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [3:0] qtr_div;
  logic       start, stop, rx, ack_sel, buf_wr, buf_rd, done_clr;
  logic [7:0] wdata, rdata;
  logic       done, nack, busy, scl_oe, sda_oe, sda_in;

  // bench slave
  logic       slv_en, slv_tx, slv_ack, slv_low;
  logic [7:0] slv_byte;

  assign sda_in = !(sda_oe | slv_low);

  i2cm_byte_engine #(.CLK_HZ(1_000_000), .DIV_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .qtr_div_i(qtr_div),
    .start_i(start), .stop_i(stop), .rx_i(rx), .ack_sel_i(ack_sel),
    .buf_wr_i(buf_wr), .buf_rd_i(buf_rd), .buf_wdata_i(wdata),
    .buf_rdata_o(rdata), .done_clr_i(done_clr), .done_o(done),
    .nack_o(nack), .busy_o(busy), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .sda_i(sda_in)
  );

  int n_checks = 0, n_errs = 0;
  int n_start = 0, n_stop = 0, bitpos = 0, hcnt = 0, last_high = 0;
  logic [8:0] shbuf;
  logic [8:0] bus_q[$];
  logic scl_p = 1'b1, sda_p = 1'b1;

  // bus monitor and slave, evaluated every clock away from the active edge
  always @(negedge clk) begin
    logic scl, sda;
    scl = !scl_oe;
    sda = sda_in;
    if (!rst_n) begin
      slv_low = 1'b0;
      bitpos  = 0;
    end else begin
      if (scl && scl_p && sda != sda_p) begin
        if (!sda) n_start++;
        else      n_stop++;
        bitpos = 0;
      end
      if (scl && !scl_p) begin
        shbuf = {shbuf[7:0], sda};
        bitpos++;
        hcnt = 0;
        if (bitpos == 9) begin
          bus_q.push_back(shbuf);
          bitpos = 0;
        end
      end
      if (scl) hcnt++;
      if (!scl && scl_p) last_high = hcnt;
      if (!slv_en)     slv_low = 1'b0;
      else if (!scl) begin
        if (slv_tx) slv_low = (bitpos < 8) ? !slv_byte[7-bitpos] : 1'b0;
        else        slv_low = (bitpos == 8) ? slv_ack : 1'b0;
      end
    end
    scl_p = scl;
    sda_p = sda;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done, req, done, 1);
  endtask

  task automatic clr_done();
    done_clr = 1'b1;
    cyc(1);
    done_clr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wdata  = d;
    buf_wr = 1'b1;
    cyc(1);
    buf_wr = 1'b0;
  endtask

  task automatic rd();
    buf_rd = 1'b1;
    cyc(1);
    buf_rd = 1'b0;
  endtask

  task automatic chk_byte(input logic [8:0] exp, input string req);
    logic [8:0] got;
    if (bus_q.size() == 0) chk(1'b0, req, 'hfff, exp);
    else begin
      got = bus_q.pop_front();
      chk(got == exp, req, got, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; qtr_div = 4'd1; start = 0; stop = 0; rx = 0; ack_sel = 0;
    buf_wr = 0; buf_rd = 0; done_clr = 0; wdata = '0;
    slv_en = 0; slv_tx = 0; slv_ack = 1; slv_byte = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // reset state
    chk(!scl_oe && !sda_oe && !busy, "R2 reset lines", {scl_oe, sda_oe, busy}, 0);
    chk(!done, "R7 reset done", done, 0);

    // R1: START from idle, address byte acked
    wr(8'hA6);
    slv_en = 1; slv_tx = 0; slv_ack = 1;
    start = 1;
    wait_done("R7 first byte");
    chk(n_start == 1, "R1 start count", n_start, 1);
    chk_byte({8'hA6, 1'b0}, "R1 first byte");
    chk(!nack, "R6 ack seen", nack, 0);
    chk(last_high == 4, "R11 scl high div1", last_high, 4);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (!scl_oe || busy) bad++;
      cyc(1);
    end
    chk(bad == 0, "R4 scl parked low", bad, 0);
    clr_done();
    chk(!done, "R7 done cleared", done, 0);

    // R6: slave NACK, then R8: access inside settle window
    slv_ack = 0;
    wr(8'h3C);
    wait_done("R7 second byte");
    wr(8'h55);
    cyc(4);
    chk(!busy && scl_oe, "R8 early write no resume", busy, 0);
    chk(rdata == 8'h3C, "R8 early write not loaded", rdata, 8'h3C);
    chk_byte({8'h3C, 1'b1}, "R3 sent byte");
    chk(nack, "R6 nack seen", nack, 1);
    clr_done();
    cyc(15);
    slv_ack = 1;
    wr(8'h81);
    wait_done("R8 late write resumes");
    chk_byte({8'h81, 1'b0}, "R8 late write byte");
    chk(!nack, "R6 nack cleared", nack, 0);
    clr_done();

    // R3/R5: receive with ACK then NACK
    cyc(15);
    rx = 1; ack_sel = 0; slv_tx = 1; slv_byte = 8'hD2;
    rd();
    wait_done("R3 read byte");
    chk_byte({8'hD2, 1'b0}, "R5 ack returned");
    chk(rdata == 8'hD2, "R3 read data", rdata, 8'hD2);
    slv_en = 0;
    clr_done();
    cyc(15);
    ack_sel = 1; slv_byte = 8'h4B; slv_en = 1;
    rd();
    wait_done("R3 read byte 2");
    chk_byte({8'h4B, 1'b1}, "R5 nack returned");
    chk(rdata == 8'h4B, "R3 read data 2", rdata, 8'h4B);
    slv_en = 0;
    clr_done();

    // R9 repeated START; R10 start edge during byte ignored
    rx = 0; slv_tx = 0; slv_ack = 1; slv_en = 1;
    start = 0;
    cyc(15);
    wr(8'h90);
    cyc(4);
    chk(!busy && rdata == 8'h90, "R3 load without resume", rdata, 8'h90);
    start = 1;
    cyc(20);
    start = 0;
    cyc(4);
    start = 1;
    wait_done("R9 restart byte");
    chk(n_start == 2, "R10 start during byte ignored", n_start, 2);
    chk_byte({8'h90, 1'b0}, "R9 restart byte data");
    clr_done();

    // R2 STOP with start held 1
    slv_en = 0;
    stop = 1;
    cyc(30);
    chk(n_stop == 1, "R2 stop count", n_stop, 1);
    chk(!scl_oe && !sda_oe && !busy, "R2 lines released", {scl_oe, sda_oe, busy}, 0);

    // R10: start edge while stop is 1
    start = 0;
    cyc(3);
    start = 1;
    cyc(30);
    chk(n_start == 2 && !busy && !scl_oe, "R10 start with stop ignored", n_start, 2);

    // R11 slower divider, START from idle again
    stop = 0; start = 0; qtr_div = 4'd3;
    cyc(3);
    wr(8'h5A);
    slv_en = 1; slv_tx = 0; slv_ack = 1;
    start = 1;
    wait_done("R1 second start");
    chk(n_start == 3, "R1 start count 2", n_start, 3);
    chk_byte({8'h5A, 1'b0}, "R1 byte after idle");
    chk(last_high == 8, "R11 scl high div3", last_high, 8);
    clr_done();
    slv_en = 0;
    stop = 1;
    cyc(60);
    chk(n_stop == 2, "R2 second stop", n_stop, 2);
    chk(bus_q.size() == 0, "R10 no stray bytes", bus_q.size(), 0);

    summary();
    $finish;
  end
endmodule